// File: doc/BRIEF.md
# Page-Mode Pseudo-Static RAM Controller

This block sits between a synchronous host and a 2M x 16 pseudo-static RAM that has an asynchronous, SRAM-like strobe interface. The host hands over one request at a time (single read, single write, page read of up to four words, or a sleep request). The controller turns each request into chip-select, write-strobe, read-strobe and byte-lane strobes whose widths are whole clock cycles. Each cycle count is worked out at elaboration time from a nanosecond parameter and the clock-period parameter. Minimum times are rounded up and the single maximum time is rounded down.

Page reads hold the upper address bits and step only the two lowest bits, wrapping inside the four-word page. The first word takes the full access time and each later word takes the short in-page time. A counter tracks how long chip select has been low and cuts a burst short so that chip select never stays low for the maximum time. The controller also owns the direction of the data pins. It waits out the memory's output float time before it drives write data. It parks the sleep pin low only while chip select is high, so the configuration-register strobe pattern can never appear.

Top module: `psram_page_ctrl`

## Requirements
- R1: During and after reset, `mem_ce_n`, `mem_we_n`, `mem_oe_n`, `mem_ub_n`, `mem_lb_n` and `mem_zz_n` are 1, `mem_dq_oe` is 0, `rsp_valid` is 0 and `req_ready` is 1.
- R2: A read (`req_cmd`=0) accepted at clock edge E0 drives `mem_ce_n` and `mem_oe_n` low from E0. It returns `mem_dq_in` on `rsp_data`, with `rsp_valid` and `rsp_last` both 1 for exactly one cycle. That cycle follows edge E0+AA, where AA = ceil(T_AA_NS / CLK_NS) (6 cycles at default values).
- R3: A page read (`req_cmd`=2, `req_len` = words-1) returns words at E0+AA, E0+AA+PA, E0+AA+2PA and so on, where PA = ceil(T_PA_NS / CLK_NS). `mem_addr[20:2]` stays fixed, `mem_addr[1:0]` increments and wraps from 3 to 0, and `rsp_last` is 1 only on the final word.
- R4: Let L = floor(T_CEMAX_NS / CLK_NS). When a word completes after chip select has been low for at least L-PA cycles, the burst ends on that word with `rsp_last`=1, even if more words were requested. `mem_ce_n` is never low for L or more consecutive cycles.
- R5: A write (`req_cmd`=1) holds `mem_ce_n`, `mem_we_n` and `mem_dq_oe` active for exactly max(ceil(T_WC), ceil(T_WP), ceil(T_DW)) cycles (6 at defaults), with `mem_dq_out` equal to the request data. `mem_oe_n` stays 1 whenever `mem_we_n` is 0.
- R6: `req_be[1]` selects the upper byte (bits 15..8, `mem_ub_n` low) and `req_be[0]` selects the lower byte (bits 7..0, `mem_lb_n` low). A write leaves unselected bytes unchanged in memory, and a read returns 0 in unselected byte lanes of `rsp_data`.
- R7: After a read, `mem_ce_n` and `mem_oe_n` are high for ceil(T_HZ_NS / CLK_NS) cycles before `req_ready` returns. `mem_dq_oe` is never 1 while `mem_oe_n` is 0, and it rises only after `mem_oe_n` was already high in the previous cycle.
- R8: A sleep request (`req_cmd`=3) drives `mem_zz_n` low from the accept edge while `mem_ce_n` stays high. `mem_ce_n` and `mem_zz_n` are never low together.
- R9: A non-sleep request accepted while asleep raises `mem_zz_n` at once. It waits W = ceil(T_WAKE_NS / CLK_NS) cycles and then starts the request, so a read's chip select falls W cycles and its data arrives W+AA cycles after the accept edge.
- R10: `req_ready` is 1 only when idle or asleep. It is 0 during any access, and a request is accepted on a clock edge where `req_valid` and `req_ready` are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller can accept a request |
| req_cmd | input | 2 | 0 read, 1 write, 2 page read, 3 sleep |
| req_addr | input | 21 | Word address |
| req_len | input | 2 | Page read word count minus one |
| req_be | input | 2 | Byte enables, bit 1 upper, bit 0 lower |
| req_wdata | input | 16 | Write data |
| rsp_valid | output | 1 | One-cycle pulse per read word |
| rsp_data | output | 16 | Read word, unselected lanes zero |
| rsp_last | output | 1 | Final word of the request |
| mem_addr | output | 21 | Memory address |
| mem_ce_n | output | 1 | Chip select, active low |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_oe_n | output | 1 | Read strobe, active low |
| mem_ub_n | output | 1 | Upper byte select, active low |
| mem_lb_n | output | 1 | Lower byte select, active low |
| mem_zz_n | output | 1 | Sleep pin, low for deep sleep |
| mem_dq_out | output | 16 | Data toward the memory |
| mem_dq_oe | output | 1 | Drive enable for the data pins |
| mem_dq_in | input | 16 | Data from the memory |

## Verification
Every result is due a fixed number of edges after the accept edge E0. Chip select falls right after E0 (after E0+W from sleep). Read words follow E0+AA and each PA after that. Write strobes last 6 cycles, and `req_ready` comes back one cycle after the final read word. The bench counts edges from the accept edge and samples on the falling edge in the middle of each cycle, so each check lands on the exact cycle it names. The bench's memory model returns a poison word unless the chip has been selected for AA cycles and the address has been stable for PA cycles, so any early capture shows up as a data mismatch and not only as a timing mismatch.

// File: rtl/psc_pkg.sv
package psc_pkg;

    typedef enum logic [1:0] {
        CMD_READ  = 2'd0,
        CMD_WRITE = 2'd1,
        CMD_PAGE  = 2'd2,
        CMD_SLEEP = 2'd3
    } cmd_e;

    // minimum times: round up, never below one cycle
    function automatic int unsigned cyc_min(int unsigned ns, int unsigned per);
        int unsigned c;
        c = (ns + per - 1) / per;
        return (c == 0) ? 1 : c;
    endfunction

    // maximum times: round down so the limit is never exceeded
    function automatic int unsigned cyc_max(int unsigned ns, int unsigned per);
        return ns / per;
    endfunction

    function automatic int unsigned max3(int unsigned a, int unsigned b, int unsigned c);
        int unsigned m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/psc_ce_guard.sv
module psc_ce_guard #(
    parameter int unsigned LIMIT_CYC = 1000,
    parameter int unsigned PA_CYC    = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ce_n,
    output logic near_limit
);
    localparam int unsigned CNT_W = $clog2(LIMIT_CYC + 1);
    localparam logic [CNT_W-1:0] CNT_SAT = CNT_W'(LIMIT_CYC);
    // cycles already spent low, counted before the current one
    localparam logic [CNT_W-1:0] THRESH_M1 = CNT_W'(LIMIT_CYC - PA_CYC - 1);

    logic [CNT_W-1:0] low_cnt_d, low_cnt_q;

    always_comb begin
        if (ce_n)
            low_cnt_d = '0;
        else if (low_cnt_q == CNT_SAT)
            low_cnt_d = low_cnt_q;
        else
            low_cnt_d = low_cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) low_cnt_q <= '0;
        else        low_cnt_q <= low_cnt_d;
    end

    assign near_limit = !ce_n && (low_cnt_q >= THRESH_M1);

    // R4: chip select never reaches the limit
    assert_ce_low_limit_R4: assert property (@(posedge clk) disable iff (!rst_n)
        low_cnt_q < CNT_W'(LIMIT_CYC - 1));

endmodule

// File: rtl/psc_seq.sv
module psc_seq
    import psc_pkg::*;
#(
    parameter int unsigned AW       = 21,
    parameter int unsigned DW       = 16,
    parameter int unsigned AA_CYC   = 6,
    parameter int unsigned PA_CYC   = 2,
    parameter int unsigned WR_CYC   = 6,
    parameter int unsigned HZ_CYC   = 1,
    parameter int unsigned WAKE_CYC = 15
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic [1:0]    req_cmd,
    input  logic [AW-1:0] req_addr,
    input  logic [1:0]    req_len,
    input  logic [1:0]    req_be,
    input  logic [DW-1:0] req_wdata,
    input  logic          near_limit,
    output logic          rsp_valid,
    output logic [DW-1:0] rsp_data,
    output logic          rsp_last,
    output logic [AW-1:0] mem_addr,
    output logic          mem_ce_n,
    output logic          mem_we_n,
    output logic          mem_oe_n,
    output logic          mem_ub_n,
    output logic          mem_lb_n,
    output logic          mem_zz_n,
    output logic [DW-1:0] mem_dq_out,
    output logic          mem_dq_oe,
    input  logic [DW-1:0] mem_dq_in
);
    localparam int unsigned LANE_W = DW / 2;
    localparam int unsigned MAX_A  = max3(AA_CYC, PA_CYC, WR_CYC);
    localparam int unsigned MAX_C  = max3(MAX_A, HZ_CYC, WAKE_CYC);
    localparam int unsigned CW     = $clog2(MAX_C + 1);

    typedef enum logic [2:0] {
        S_IDLE, S_RD, S_WR, S_RECOV, S_SLEEP, S_WAKE
    } st_e;

    typedef struct packed {
        st_e           st;
        logic [CW-1:0] cnt;
        logic [AW-1:0] addr;
        logic [1:0]    left;
        logic [1:0]    be;
        logic [DW-1:0] wdata;
        cmd_e          cmd;
        logic          ce_n;
        logic          we_n;
        logic          oe_n;
        logic          ub_n;
        logic          lb_n;
        logic          zz_n;
        logic          drive;
        logic          rvalid;
        logic          rlast;
        logic [DW-1:0] rdata;
    } seq_t;

    seq_t q, n, s;
    logic accept;

    function automatic seq_t idle_val();
        seq_t r;
        r       = '0;
        r.st    = S_IDLE;
        r.cmd   = CMD_READ;
        r.ce_n  = 1'b1;
        r.we_n  = 1'b1;
        r.oe_n  = 1'b1;
        r.ub_n  = 1'b1;
        r.lb_n  = 1'b1;
        r.zz_n  = 1'b1;
        return r;
    endfunction

    // start the access held in r
    function automatic seq_t launch(seq_t r);
        seq_t o;
        o = r;
        case (r.cmd)
            CMD_READ, CMD_PAGE: begin
                o.st   = S_RD;
                o.ce_n = 1'b0;
                o.oe_n = 1'b0;
                o.ub_n = !r.be[1];
                o.lb_n = !r.be[0];
                o.cnt  = CW'(AA_CYC - 1);
            end
            CMD_WRITE: begin
                o.st    = S_WR;
                o.ce_n  = 1'b0;
                o.we_n  = 1'b0;
                o.ub_n  = !r.be[1];
                o.lb_n  = !r.be[0];
                o.drive = 1'b1;
                o.cnt   = CW'(WR_CYC - 1);
            end
            default: begin
                o.st   = S_SLEEP;
                o.zz_n = 1'b0;
            end
        endcase
        return o;
    endfunction

    assign req_ready = (q.st == S_IDLE) || (q.st == S_SLEEP);
    assign accept    = req_valid && req_ready;

    always_comb begin
        s        = q;
        s.addr   = req_addr;
        s.be     = req_be;
        s.wdata  = req_wdata;
        s.cmd    = cmd_e'(req_cmd);
        s.left   = (cmd_e'(req_cmd) == CMD_PAGE) ? req_len : 2'd0;
        s.rvalid = 1'b0;
        s.rlast  = 1'b0;

        n        = q;
        n.rvalid = 1'b0;
        n.rlast  = 1'b0;

        case (q.st)
            S_IDLE, S_SLEEP: begin
                if (accept) begin
                    if (q.st == S_SLEEP && s.cmd != CMD_SLEEP) begin
                        n      = s;
                        n.st   = S_WAKE;
                        n.zz_n = 1'b1;
                        n.cnt  = CW'(WAKE_CYC - 1);
                    end else begin
                        n = launch(s);
                    end
                end
            end
            S_WAKE: begin
                if (q.cnt != '0) n.cnt = q.cnt - 1'b1;
                else             n = launch(q);
            end
            S_RD: begin
                if (q.cnt != '0) begin
                    n.cnt = q.cnt - 1'b1;
                end else begin
                    n.rvalid = 1'b1;
                    n.rdata  = mem_dq_in & {{LANE_W{q.be[1]}}, {LANE_W{q.be[0]}}};
                    if (q.left != 2'd0 && !near_limit) begin
                        n.left      = q.left - 2'd1;
                        n.addr[1:0] = q.addr[1:0] + 2'd1;
                        n.cnt       = CW'(PA_CYC - 1);
                    end else begin
                        n.rlast = 1'b1;
                        n.st    = S_RECOV;
                        n.ce_n  = 1'b1;
                        n.oe_n  = 1'b1;
                        n.ub_n  = 1'b1;
                        n.lb_n  = 1'b1;
                        n.cnt   = CW'(HZ_CYC - 1);
                    end
                end
            end
            S_WR: begin
                if (q.cnt != '0) begin
                    n.cnt = q.cnt - 1'b1;
                end else begin
                    n.st    = S_IDLE;
                    n.ce_n  = 1'b1;
                    n.we_n  = 1'b1;
                    n.ub_n  = 1'b1;
                    n.lb_n  = 1'b1;
                    n.drive = 1'b0;
                end
            end
            S_RECOV: begin
                if (q.cnt != '0) n.cnt = q.cnt - 1'b1;
                else             n.st  = S_IDLE;
            end
            default: n = idle_val();
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= idle_val();
        else        q <= n;
    end

    assign rsp_valid  = q.rvalid;
    assign rsp_data   = q.rdata;
    assign rsp_last   = q.rlast;
    assign mem_addr   = q.addr;
    assign mem_ce_n   = q.ce_n;
    assign mem_we_n   = q.we_n;
    assign mem_oe_n   = q.oe_n;
    assign mem_ub_n   = q.ub_n;
    assign mem_lb_n   = q.lb_n;
    assign mem_zz_n   = q.zz_n;
    assign mem_dq_out = q.wdata;
    assign mem_dq_oe  = q.drive;

    // R8: never the configuration-register pattern
    assert_no_cfg_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(!q.ce_n && !q.zz_n));
    // R5: read strobe held off through a write
    assert_oe_off_in_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !q.we_n |-> q.oe_n);
    // R7: no drive while the memory may drive
    assert_no_bus_fight_R7: assert property (@(posedge clk) disable iff (!rst_n)
        q.drive |-> q.oe_n);
    // R7: drive starts only after the float cycle
    assert_drive_after_float_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.drive) |-> $past(q.oe_n));
    // R10: no acceptance while the chip is selected
    assert_ready_only_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> q.ce_n);
    // R3: end-of-request marker only on a delivered word
    assert_last_with_valid_R3: assert property (@(posedge clk) disable iff (!rst_n)
        q.rlast |-> q.rvalid);

endmodule

// File: rtl/psram_page_ctrl.sv
module psram_page_ctrl
    import psc_pkg::*;
#(
    parameter int unsigned ADDR_W     = 21,
    parameter int unsigned DATA_W     = 16,
    parameter int unsigned CLK_NS     = 10,
    parameter int unsigned T_AA_NS    = 60,
    parameter int unsigned T_PA_NS    = 15,
    parameter int unsigned T_WC_NS    = 60,
    parameter int unsigned T_WP_NS    = 40,
    parameter int unsigned T_DW_NS    = 20,
    parameter int unsigned T_HZ_NS    = 8,
    parameter int unsigned T_CEMAX_NS = 10000,
    parameter int unsigned T_WAKE_NS  = 150
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [1:0]        req_cmd,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_len,
    input  logic [1:0]        req_be,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_data,
    output logic              rsp_last,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_ce_n,
    output logic              mem_we_n,
    output logic              mem_oe_n,
    output logic              mem_ub_n,
    output logic              mem_lb_n,
    output logic              mem_zz_n,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_in
);
    localparam int unsigned AA_C   = cyc_min(T_AA_NS, CLK_NS);
    localparam int unsigned PA_C   = cyc_min(T_PA_NS, CLK_NS);
    localparam int unsigned WR_C   = max3(cyc_min(T_WC_NS, CLK_NS),
                                          cyc_min(T_WP_NS, CLK_NS),
                                          cyc_min(T_DW_NS, CLK_NS));
    localparam int unsigned HZ_C   = cyc_min(T_HZ_NS, CLK_NS);
    localparam int unsigned WAKE_C = cyc_min(T_WAKE_NS, CLK_NS);
    localparam int unsigned LIM_C  = cyc_max(T_CEMAX_NS, CLK_NS);

    logic near_limit;
    logic ce_n_int;

    psc_ce_guard #(
        .LIMIT_CYC (LIM_C),
        .PA_CYC    (PA_C)
    ) i_guard (
        .clk        (clk),
        .rst_n      (rst_n),
        .ce_n       (ce_n_int),
        .near_limit (near_limit)
    );

    psc_seq #(
        .AW       (ADDR_W),
        .DW       (DATA_W),
        .AA_CYC   (AA_C),
        .PA_CYC   (PA_C),
        .WR_CYC   (WR_C),
        .HZ_CYC   (HZ_C),
        .WAKE_CYC (WAKE_C)
    ) i_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_ready  (req_ready),
        .req_cmd    (req_cmd),
        .req_addr   (req_addr),
        .req_len    (req_len),
        .req_be     (req_be),
        .req_wdata  (req_wdata),
        .near_limit (near_limit),
        .rsp_valid  (rsp_valid),
        .rsp_data   (rsp_data),
        .rsp_last   (rsp_last),
        .mem_addr   (mem_addr),
        .mem_ce_n   (ce_n_int),
        .mem_we_n   (mem_we_n),
        .mem_oe_n   (mem_oe_n),
        .mem_ub_n   (mem_ub_n),
        .mem_lb_n   (mem_lb_n),
        .mem_zz_n   (mem_zz_n),
        .mem_dq_out (mem_dq_out),
        .mem_dq_oe  (mem_dq_oe),
        .mem_dq_in  (mem_dq_in)
    );

    assign mem_ce_n = ce_n_int;

endmodule

// File: tb/test_psram_page_ctrl.sv
module test_psram_page_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int AA = 6;
    localparam int PA = 2;
    localparam int WR = 6;
    localparam int WK = 5;
    localparam int LIM = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic req_ready;
    logic [1:0] req_cmd = 2'd0;
    logic [20:0] req_addr = '0;
    logic [1:0] req_len = 2'd0;
    logic [1:0] req_be = 2'd3;
    logic [15:0] req_wdata = '0;
    logic rsp_valid, rsp_last;
    logic [15:0] rsp_data;
    logic [20:0] mem_addr;
    logic mem_ce_n, mem_we_n, mem_oe_n, mem_ub_n, mem_lb_n, mem_zz_n, mem_dq_oe;
    logic [15:0] mem_dq_out;
    logic [15:0] mem_dq_in;

    always #(CLK_PERIOD/2) clk = ~clk;

    psram_page_ctrl #(
        .T_CEMAX_NS (120),
        .T_WAKE_NS  (50)
    ) i_psram_page_ctrl (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_cmd(req_cmd), .req_addr(req_addr), .req_len(req_len), .req_be(req_be),
        .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .rsp_last(rsp_last), .mem_addr(mem_addr), .mem_ce_n(mem_ce_n),
        .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n), .mem_ub_n(mem_ub_n),
        .mem_lb_n(mem_lb_n), .mem_zz_n(mem_zz_n), .mem_dq_out(mem_dq_out),
        .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
    );

    // memory model: poison data until access and page times are met
    logic [15:0] mem [0:63];
    int acc_cnt = 0;
    int stab_cnt = 0;
    logic [20:0] prev_addr = '0;
    wire [5:0] ma = mem_addr[5:0];

    always_comb begin
        if (!mem_ce_n && !mem_oe_n && mem_we_n) begin
            if (acc_cnt >= AA && stab_cnt >= PA)
                mem_dq_in = {mem_ub_n ? 8'h00 : mem[ma][15:8], mem_lb_n ? 8'h00 : mem[ma][7:0]};
            else
                mem_dq_in = 16'hBAD0;
        end else begin
            mem_dq_in = 16'h0000;
        end
    end

    // bus monitors
    int cfg_bad = 0;
    int fight_bad = 0;
    int ce_run = 0;
    int ce_run_max = 0;

    always @(negedge clk) begin
        if (mem_ce_n) begin
            acc_cnt  <= 0;
            stab_cnt <= 0;
        end else begin
            acc_cnt  <= acc_cnt + 1;
            stab_cnt <= (mem_addr == prev_addr) ? stab_cnt + 1 : 1;
        end
        prev_addr <= mem_addr;
        if (!mem_ce_n && !mem_we_n && mem_dq_oe) begin
            if (!mem_ub_n) mem[ma][15:8] <= mem_dq_out[15:8];
            if (!mem_lb_n) mem[ma][7:0]  <= mem_dq_out[7:0];
        end
        if (rst_n) begin
            if (!mem_ce_n && !mem_zz_n) cfg_bad++;
            if (mem_dq_oe && !mem_oe_n) fight_bad++;
            if (!mem_ce_n) ce_run++; else ce_run = 0;
            if (ce_run > ce_run_max) ce_run_max = ce_run;
        end
    end

    int n_chk = 0;
    int n_bad = 0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic send(input logic [1:0] cmd, input logic [20:0] a,
                        input logic [1:0] len, input logic [1:0] be, input logic [15:0] d);
        @(negedge clk);
        req_cmd = cmd; req_addr = a; req_len = len; req_be = be; req_wdata = d;
        req_valid = 1'b1;
        while (!req_ready) @(negedge clk);
        @(posedge clk);
        #1 req_valid = 1'b0;
    endtask

    int got_n;
    logic [15:0] got_d [0:3];
    int got_k [0:3];
    logic got_l [0:3];
    int upper_bad;

    task automatic collect(input logic [20:0] a);
        got_n = 0;
        upper_bad = 0;
        for (int k = 0; k < 40; k++) begin
            @(negedge clk);
            if (!mem_ce_n && mem_addr[20:2] != a[20:2]) upper_bad++;
            if (rsp_valid && got_n < 4) begin
                got_d[got_n] = rsp_data;
                got_k[got_n] = k;
                got_l[got_n] = rsp_last;
                got_n++;
                if (rsp_last) break;
            end
        end
    endtask

    task automatic do_write(input logic [20:0] a, input logic [1:0] be, input logic [15:0] d);
        int wl;
        int okc;
        wl = 0; okc = 0;
        send(2'd1, a, 2'd0, be, d);
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            if (!mem_we_n) begin
                wl++;
                if (!mem_ce_n && mem_oe_n && mem_dq_oe && mem_dq_out == d &&
                    mem_ub_n == !be[1] && mem_lb_n == !be[0] && mem_addr == a) okc++;
            end else if (wl > 0) begin
                break;
            end
        end
        chk("R5 write strobe cycles", wl, WR);
        chk("R5 write strobes/data while low", okc, WR);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 strobes in reset", {mem_ce_n, mem_we_n, mem_oe_n, mem_ub_n, mem_lb_n, mem_zz_n}, 6'h3F);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 strobes after reset", {mem_ce_n, mem_we_n, mem_oe_n, mem_ub_n, mem_lb_n, mem_zz_n}, 6'h3F);
        chk("R1 drive/valid/ready", {mem_dq_oe, rsp_valid, req_ready}, 3'b001);
    endtask

    task automatic t_write_read();
        do_write(21'h0_0005, 2'b11, 16'hA5C3);
        send(2'd0, 21'h0_0005, 2'd0, 2'b11, 16'h0);
        @(negedge clk);
        chk("R2 ce/oe low at accept", {mem_ce_n, mem_oe_n}, 2'b00);
        chk("R10 ready low during read", req_ready, 1'b0);
        got_n = 0;
        for (int k = 1; k < 30; k++) begin
            @(negedge clk);
            if (rsp_valid) begin
                got_d[0] = rsp_data; got_k[0] = k; got_l[0] = rsp_last; got_n = 1;
                break;
            end
        end
        chk("R2 read latency", got_k[0], AA);
        chk("R2 read data", got_d[0], 16'hA5C3);
        chk("R2 read last", got_l[0], 1'b1);
        @(negedge clk);
        chk("R2 valid is a single pulse", rsp_valid, 1'b0);
    endtask

    task automatic t_byte_mask();
        do_write(21'h0_0005, 2'b10, 16'h1234);
        send(2'd0, 21'h0_0005, 2'd0, 2'b11, 16'h0);
        collect(21'h0_0005);
        chk("R6 upper-only write", got_d[0], 16'h12C3);
        do_write(21'h0_0005, 2'b01, 16'hFF77);
        send(2'd0, 21'h0_0005, 2'd0, 2'b11, 16'h0);
        collect(21'h0_0005);
        chk("R6 lower-only write", got_d[0], 16'h1277);
        send(2'd0, 21'h0_0005, 2'd0, 2'b01, 16'h0);
        collect(21'h0_0005);
        chk("R6 read lane mask", got_d[0], 16'h0077);
    endtask

    task automatic t_page();
        for (int i = 0; i < 4; i++)
            do_write(21'h1F_0008 + 21'(i), 2'b11, 16'h4000 + 16'(i));
        send(2'd2, 21'h1F_000A, 2'd2, 2'b11, 16'h0);
        collect(21'h1F_000A);
        chk("R3 page word count", got_n, 3);
        chk("R3 page word0", {got_d[0], 16'(got_k[0])}, {16'h4002, 16'(AA)});
        chk("R3 page word1", {got_d[1], 16'(got_k[1])}, {16'h4003, 16'(AA + PA)});
        chk("R3 page word2 wraps", {got_d[2], 16'(got_k[2])}, {16'h4000, 16'(AA + 2*PA)});
        chk("R3 last flags", {got_l[0], got_l[1], got_l[2]}, 3'b001);
        chk("R3 upper address fixed", upper_bad, 0);
    endtask

    task automatic t_limit();
        send(2'd2, 21'h1F_0008, 2'd3, 2'b11, 16'h0);
        collect(21'h1F_0008);
        chk("R4 burst cut to 3 words", got_n, 3);
        chk("R4 last on cut word", {got_l[2], got_d[2]}, {1'b1, 16'h4002});
    endtask

    task automatic t_turnaround();
        send(2'd0, 21'h0_0005, 2'd0, 2'b11, 16'h0);
        collect(21'h0_0005);
        chk("R7 float cycle strobes/ready", {mem_ce_n, mem_oe_n, req_ready}, 3'b110);
        @(negedge clk);
        chk("R7 ready after float", req_ready, 1'b1);
        do_write(21'h0_0006, 2'b11, 16'h5A5A);
    endtask

    task automatic t_sleep_wake();
        int ce_k;
        int rsp_k;
        logic zz0;
        send(2'd3, 21'h0, 2'd0, 2'b11, 16'h0);
        @(negedge clk);
        chk("R8 sleep pin low, chip off", {mem_zz_n, mem_ce_n, req_ready}, 3'b011);
        repeat (3) @(negedge clk);
        chk("R8 sleep held", mem_zz_n, 1'b0);
        send(2'd0, 21'h0_0006, 2'd0, 2'b11, 16'h0);
        ce_k = -1; rsp_k = -1; zz0 = 1'b0;
        for (int k = 0; k < 30; k++) begin
            @(negedge clk);
            if (k == 0) zz0 = mem_zz_n;
            if (!mem_ce_n && ce_k < 0) ce_k = k;
            if (rsp_valid) begin
                rsp_k = k;
                chk("R9 data after wake", rsp_data, 16'h5A5A);
                break;
            end
        end
        chk("R9 sleep pin raised at accept", zz0, 1'b1);
        chk("R9 chip select after wake time", ce_k, WK);
        chk("R9 data latency from sleep", rsp_k, WK + AA);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 64; i++) mem[i] = 16'(i * 3);
        t_reset();
        t_write_read();
        t_byte_mask();
        t_page();
        t_limit();
        t_turnaround();
        t_sleep_wake();
        repeat (3) @(negedge clk);
        chk("R8 no chip select during sleep", cfg_bad, 0);
        chk("R7 no bus fight", fight_bad, 0);
        chk("R4 chip select run below limit", ce_run_max < LIM, 1'b1);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule